// File: doc/BRIEF.md
# External Area Chip-Select Generator

This block turns each external bus cycle into an active-low select on one of eight lines, one line per external memory area. The three most significant address bits name the area. A bus cycle opens with a one-cycle start pulse that carries a valid address and a flag saying whether the target is on-chip. It closes with an end pulse. For the whole of an external cycle, exactly one select is held low. An on-chip cycle leaves every select high.

Each of the eight pads has its own output enable. The lower four enables come from a port direction register, and the upper four come from a select control register. Writes to either register are staged, and they apply only when the next bus cycle starts, so no pad changes state in the middle of a cycle. The reset value of the lower group depends on the operating mode: with on-chip ROM disabled, select 0 comes up driven; with on-chip ROM enabled, all four come up undriven. The upper group always resets undriven.

Top module: `cs_area_select`

## Requirements
- R1: While reset (rstN low, synchronous) is sampled, every bit of csN goes to 1, including in the middle of a bus cycle.
- R2: After reset, csOe equals 8'h01 when modeRomEn was 0 during reset, and 8'h00 when it was 1.
- R3: A busStart sampled with onChip=0 and busAddr[23:21]=n drives csN[n] low and all other csN bits high, from that same clock edge onward. The lower address bits have no effect.
- R4: A busEnd sampled without busStart returns csN to 8'hFF at that edge. A busEnd while the bus is idle has no effect.
- R5: A busStart sampled with onChip=1 keeps csN at 8'hFF for the whole cycle.
- R6: At most one csN bit is low at any time, and none is low while the bus is idle.
- R7: csOe[3:0] follows the lower-group direction bits written through lowWrEn/lowWrData. A 1 enables the pad. csN still carries the decode while its enable is 0.
- R8: csOe[7:4] follows the upper-group control bits written through highWrEn/highWrData. A 1 enables the pad.
- R9: A register write changes csOe only at the first busStart sampled after the write edge. A write on the same edge as a busStart waits for the following cycle.
- R10: A busStart sampled together with busEnd closes the old cycle and selects the new area in the same edge.
- R11: Between the start and the end of a cycle, csN holds its value even when busAddr or onChip change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeRomEn | input | 1 | Operating mode: 1 when on-chip ROM is enabled; sampled during reset |
| busAddr | input | 24 | Bus address; the top three bits select the area |
| busStart | input | 1 | One-cycle pulse that opens a bus cycle with a valid address |
| busEnd | input | 1 | One-cycle pulse that closes the current bus cycle |
| onChip | input | 1 | Qualifies busStart: the cycle targets on-chip ROM, RAM or registers |
| lowWrEn | input | 1 | Write strobe for the lower-group direction bits |
| lowWrData | input | 4 | New direction bits for selects 0 to 3 |
| highWrEn | input | 1 | Write strobe for the upper-group control bits |
| highWrData | input | 4 | New enable bits for selects 4 to 7 |
| csN | output | 8 | Active-low select value per area |
| csOe | output | 8 | Pad output enable per area; 0 means the pad is high-impedance |

## Verification
The bench uses the default parameters: a 24-bit address and a lower group of four selects. With these values all eight areas, both enable registers and both reset modes can be reached. The vectors vary the low address bits with every entry, which shows that only the top three bits decide the area. Directed tests cover the register-write timing, back-to-back cycles and reset in both modes.

// File: rtl/cs_area_pkg.sv
package cs_area_pkg;

  // Strobes from the cycle control to the select datapath
  typedef struct packed {
    logic loadSel;   // a bus cycle starts on this edge
    logic extSel;    // the starting cycle targets external memory
    logic clearSel;  // the current cycle ends with no new one starting
    logic latchEn;   // move staged enable bits into the active set
  } csStrobe_t;

endpackage

// File: rtl/cs_area_ctrl.sv
module cs_area_ctrl
  import cs_area_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busStart,
  input  logic      busEnd,
  input  logic      onChip,
  output csStrobe_t strobes
);

  logic busy;

  // Cycle tracking: a start always wins over an end on the same edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (busStart) begin
      busy <= 1'b1;
    end else if (busEnd) begin
      busy <= 1'b0;
    end
  end

  always_comb begin
    strobes.loadSel  = busStart;
    strobes.extSel   = busStart & ~onChip;
    strobes.clearSel = busEnd & busy & ~busStart;
    strobes.latchEn  = busStart;
  end

endmodule

// File: rtl/cs_area_dp.sv
module cs_area_dp
  import cs_area_pkg::*;
#(
  parameter int AREA_BITS = 3,
  parameter int LOW_GROUP = 4,
  localparam int NUM_AREAS = 1 << AREA_BITS,
  localparam int HIGH_W    = NUM_AREAS - LOW_GROUP
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeRomEn,
  input  logic [AREA_BITS-1:0] areaIdx,
  input  csStrobe_t            strobes,
  input  logic                 lowWrEn,
  input  logic [LOW_GROUP-1:0] lowWrData,
  input  logic                 highWrEn,
  input  logic [HIGH_W-1:0]    highWrData,
  output logic [NUM_AREAS-1:0] csN,
  output logic [NUM_AREAS-1:0] csOe
);

  logic [NUM_AREAS-1:0] areaHit;
  logic [NUM_AREAS-1:0] selReg;
  logic [LOW_GROUP-1:0] lowStaged, lowActive, lowResetVal;
  logic [HIGH_W-1:0]    highStaged, highActive;

  // One comparator per area
  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_hit
    assign areaHit[g] = (areaIdx == AREA_BITS'(g));
  end

  // With ROM disabled, select 0 comes out of reset driven
  assign lowResetVal = modeRomEn ? '0 : LOW_GROUP'(1);

  // Select register, written only at cycle boundaries
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
    end else if (strobes.loadSel) begin
      selReg <= strobes.extSel ? areaHit : '0;
    end else if (strobes.clearSel) begin
      selReg <= '0;
    end
  end

  // Staged copies take writes at once
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowStaged  <= lowResetVal;
      highStaged <= '0;
    end else begin
      if (lowWrEn)  lowStaged  <= lowWrData;
      if (highWrEn) highStaged <= highWrData;
    end
  end

  // Active copies move only when a bus cycle opens
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowActive  <= lowResetVal;
      highActive <= '0;
    end else if (strobes.latchEn) begin
      lowActive  <= lowStaged;
      highActive <= highStaged;
    end
  end

  assign csN  = ~selReg;
  assign csOe = {highActive, lowActive};

endmodule

// File: rtl/cs_area_select.sv
module cs_area_select #(
  parameter int ADDR_W    = 24,
  parameter int AREA_BITS = 3,
  parameter int LOW_GROUP = 4,
  localparam int NUM_AREAS = 1 << AREA_BITS,
  localparam int HIGH_W    = NUM_AREAS - LOW_GROUP
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeRomEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busStart,
  input  logic                 busEnd,
  input  logic                 onChip,
  input  logic                 lowWrEn,
  input  logic [LOW_GROUP-1:0] lowWrData,
  input  logic                 highWrEn,
  input  logic [HIGH_W-1:0]    highWrData,
  output logic [NUM_AREAS-1:0] csN,
  output logic [NUM_AREAS-1:0] csOe
);

  import cs_area_pkg::*;

  csStrobe_t            strobes;
  logic [AREA_BITS-1:0] areaIdx;
  logic                 unusedAddrBits;

  assign areaIdx        = busAddr[ADDR_W-1 -: AREA_BITS];
  assign unusedAddrBits = ^busAddr[ADDR_W-AREA_BITS-1:0];

  cs_area_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busStart (busStart),
    .busEnd   (busEnd),
    .onChip   (onChip),
    .strobes  (strobes)
  );

  cs_area_dp #(
    .AREA_BITS (AREA_BITS),
    .LOW_GROUP (LOW_GROUP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .modeRomEn  (modeRomEn),
    .areaIdx    (areaIdx),
    .strobes    (strobes),
    .lowWrEn    (lowWrEn),
    .lowWrData  (lowWrData),
    .highWrEn   (highWrEn),
    .highWrData (highWrData),
    .csN        (csN),
    .csOe       (csOe)
  );

endmodule

// File: rtl/cs_area_select_chk.sv
module cs_area_select_chk #(
  parameter int ADDR_W    = 24,
  parameter int AREA_BITS = 3,
  localparam int NUM_AREAS = 1 << AREA_BITS
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busStart,
  input logic                 busEnd,
  input logic                 onChip,
  input logic [NUM_AREAS-1:0] csN,
  input logic [NUM_AREAS-1:0] csOe
);

  logic [AREA_BITS-1:0] areaNow;
  logic                 unusedLow;
  assign areaNow   = busAddr[ADDR_W-1 -: AREA_BITS];
  assign unusedLow = ^busAddr[ADDR_W-AREA_BITS-1:0];

  assert_reset_R1: assert property (@(posedge clk)
    !rstN |=> csN == '1);

  assert_decode_R3: assert property (@(posedge clk) disable iff (!rstN)
    busStart && !onChip |=> csN == ~(NUM_AREAS'(1) << $past(areaNow)));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    busEnd && !busStart |=> csN == '1);

  assert_onchip_R5: assert property (@(posedge clk) disable iff (!rstN)
    busStart && onChip |=> csN == '1);

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_oe_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busStart |=> $stable(csOe));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busStart && !busEnd |=> $stable(csN));

endmodule

bind cs_area_select cs_area_select_chk #(
  .ADDR_W    (ADDR_W),
  .AREA_BITS (AREA_BITS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busStart (busStart),
  .busEnd   (busEnd),
  .onChip   (onChip),
  .csN      (csN),
  .csOe     (csOe)
);

// File: tb/cs_area_select_bench.sv
module cs_area_select_bench;

  localparam int ADDR_W = 24;
  localparam int NV     = 10;

  // Vector fields: {area[2:0], onChip, expected csN[7:0]}
  localparam logic [11:0] VEC [NV] = '{
    {3'd0, 1'b0, 8'hFE}, {3'd1, 1'b0, 8'hFD}, {3'd2, 1'b0, 8'hFB},
    {3'd3, 1'b0, 8'hF7}, {3'd4, 1'b0, 8'hEF}, {3'd5, 1'b0, 8'hDF},
    {3'd6, 1'b0, 8'hBF}, {3'd7, 1'b0, 8'h7F}, {3'd3, 1'b1, 8'hFF},
    {3'd6, 1'b1, 8'hFF}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modeRomEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busStart = 1'b0;
  logic              busEnd = 1'b0;
  logic              onChip = 1'b0;
  logic              lowWrEn = 1'b0;
  logic [3:0]        lowWrData = '0;
  logic              highWrEn = 1'b0;
  logic [3:0]        highWrData = '0;
  logic [7:0]        csN, csOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cs_area_select u_cs_area_select (
    .clk(clk), .rstN(rstN), .modeRomEn(modeRomEn), .busAddr(busAddr),
    .busStart(busStart), .busEnd(busEnd), .onChip(onChip),
    .lowWrEn(lowWrEn), .lowWrData(lowWrData),
    .highWrEn(highWrEn), .highWrData(highWrData),
    .csN(csN), .csOe(csOe)
  );

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(logic mode);
    @(negedge clk);
    rstN = 1'b0; modeRomEn = mode;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic startCyc(logic [2:0] area, logic onc, logic withEnd, logic [20:0] low);
    @(negedge clk);
    busAddr = {area, low}; busStart = 1'b1; onChip = onc; busEnd = withEnd;
    @(negedge clk);
    busStart = 1'b0; busEnd = 1'b0; onChip = 1'b0;
  endtask

  task automatic endCyc();
    @(negedge clk);
    busEnd = 1'b1;
    @(negedge clk);
    busEnd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset(1'b0);
    check8("R1 reset csN", csN, 8'hFF);
    check8("R2 reset csOe rom off", csOe, 8'h01);

    // Table walk: decode, hold mid-cycle, release
    for (int i = 0; i < NV; i++) begin
      logic [2:0] area;
      logic       onc;
      logic [7:0] exp;
      {area, onc, exp} = VEC[i];
      startCyc(area, onc, 1'b0, 21'(i * 21'h0ab57));
      check8(onc ? "R5 on-chip stays high" : "R3 decode", csN, exp);
      busAddr = {area ^ 3'b101, 21'h1fffff}; onChip = ~onc;
      @(negedge clk);
      check8("R11 held mid-cycle", csN, exp);
      onChip = 1'b0;
      endCyc();
      check8("R4 R6 released", csN, 8'hFF);
    end

    // R9 then R7: low write waits for the next cycle
    @(negedge clk); lowWrEn = 1'b1; lowWrData = 4'b1010;
    @(negedge clk); lowWrEn = 1'b0;
    repeat (2) @(negedge clk);
    check8("R9 write idle no effect", csOe, 8'h01);
    startCyc(3'd2, 1'b0, 1'b0, 21'h0);
    check8("R7 low enables applied", csOe, 8'h0A);
    endCyc();

    // R8 and R9: high write mid-cycle
    startCyc(3'd5, 1'b0, 1'b0, 21'h00123);
    highWrEn = 1'b1; highWrData = 4'b0110;
    @(negedge clk); highWrEn = 1'b0;
    check8("R9 mid-cycle write held", csOe, 8'h0A);
    check8("R9 select unchanged", csN, 8'hDF);
    endCyc();
    check8("R9 after end still old", csOe, 8'h0A);
    startCyc(3'd1, 1'b0, 1'b0, 21'h0);
    check8("R8 high enables applied", csOe, 8'h6A);
    check8("R3 area1", csN, 8'hFD);
    endCyc();

    // R9: write on the same edge as a start waits one more cycle
    @(negedge clk);
    busAddr = {3'd4, 21'h0}; busStart = 1'b1; lowWrEn = 1'b1; lowWrData = 4'b0101;
    @(negedge clk);
    busStart = 1'b0; lowWrEn = 1'b0;
    check8("R9 same-edge write deferred", csOe, 8'h6A);
    endCyc();
    startCyc(3'd0, 1'b0, 1'b0, 21'h0);
    check8("R9 deferred write applied", csOe, 8'h65);
    endCyc();

    // R10: back-to-back cycles
    startCyc(3'd2, 1'b0, 1'b0, 21'h0);
    startCyc(3'd5, 1'b0, 1'b1, 21'h0);
    check8("R10 back-to-back select", csN, 8'hDF);
    endCyc();
    check8("R4 end after back-to-back", csN, 8'hFF);

    // R4: stray end while idle
    endCyc();
    check8("R4 idle end no effect", csN, 8'hFF);
    check8("R4 idle end csOe", csOe, 8'h65);

    // R1: reset in mid-cycle, then R2 ROM-on mode
    startCyc(3'd4, 1'b0, 1'b0, 21'h0);
    doReset(1'b1);
    check8("R1 reset mid-cycle", csN, 8'hFF);
    check8("R2 reset csOe rom on", csOe, 8'h00);

    // R7: decode still present while the pad is undriven
    startCyc(3'd0, 1'b0, 1'b0, 21'h0);
    check8("R7 decode with pad off", csN, 8'hFE);
    check8("R7 pad stays undriven", csOe, 8'h00);
    endCyc();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule